// File: doc/BRIEF.md
# Multi-channel thermal threshold monitor

This block runs periodic automatic scans over seven temperature-sensor channels. An external converter returns one 9-bit code per channel over a request/valid handshake, and a larger code means a hotter die. The block stores the latest code for each channel. It compares each code against an alarm level and a shutdown level set per channel, and it filters each crossing through a count of consecutive over-level samples. A confirmed alarm raises an interrupt and switches scanning to a shorter period. A confirmed shutdown drives one or both of two shutdown outputs, one meant for a GPIO path and one for a clock/reset unit, at a programmable polarity.

Software reaches the block through a simple single-cycle register bus. Writes take effect on the clock edge, and read data follows the address combinationally. The enable registers use a half-word write mask, so one bit can be changed without a read-modify-write. Alarm and shutdown events are recorded in two separate pending registers, and writing 1 to a pending bit clears it.

Top module: `therm_guard`

## Requirements
- R1: After reset the block is in this state. CONTROL (0x00) reads 0. Both period registers (0x1C normal, 0x20 hot) read 5000. Both debounce registers (0x24 alarm, 0x28 shutdown) read 4. Both pending registers (0x14 alarm, 0x18 shutdown) read 0. alarmIrq is 0, convReq is 0, and both shutdown outputs sit at their inactive level, which is high because the polarity bit resets to 0.
- R2: The masked registers are CONTROL (0x00), SHUT_SRC (0x04), IRQ_EN (0x08), ROUTE_GPIO (0x0C) and ROUTE_CLK (0x10). In each of them, bit n takes wdata bit n only when wdata bit n+16 is also 1. Otherwise bit n keeps its value. CONTROL bit 0 is the run enable and bit 8 is the polarity bit. In the other four registers, bit n belongs to channel n.
- R3: While run is enabled, a scan requests channels 0 through 6 in ascending order. Each request holds convReq with convChan at the channel index until a cycle in which convValid is 1. convChan never exceeds 6.
- R4: Reading 0x40+4n returns the last code accepted for channel n in bits 8:0, with all higher bits 0.
- R5: The block waits between scans. When no alarm is pending, the request for channel 0 rises exactly PERIOD clock edges after the edge that accepted channel 6. PERIOD is the value of register 0x1C.
- R6: While any bit of the alarm pending register is set, the wait uses the hot period (0x20) in place of the normal period. Once the pending register is clear, the wait goes back to the normal period.
- R7: A channel's sample is over its alarm level when code >= ALARM_LVL[n], which is register 0x80+4n. After the alarm debounce count of consecutive over-level samples, alarm pending bit n sets, but only if IRQ_EN bit n is 1. alarmIrq is the OR of all alarm pending bits.
- R8: Any sample below a channel's level resets that channel's consecutive count. A run of over-level samples that is broken before it reaches the debounce count sets no pending bit.
- R9: Writing a value to a pending register clears every bit that is 1 in that value. Writing back the value just read therefore clears all bits that were set.
- R10: Shutdown pending bit n (register 0x18) sets after the shutdown debounce count of consecutive samples with code >= SHUT_LVL[n], which is register 0xC0+4n. The bit sets only if SHUT_SRC bit n is 1.
- R11: shutGpio is active when any shutdown pending bit is set whose ROUTE_GPIO bit is also set. shutClk works the same way with ROUTE_CLK.
- R12: When CONTROL bit 8 is 1, an active shutdown output is driven high and an inactive one low. When bit 8 is 0, both levels are inverted.
- R13: A shutdown output stays active after the code drops back below the level. It releases only when its pending bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| convReq | output | 1 | Conversion request, held until accepted |
| convChan | output | 3 | Channel being converted |
| convValid | input | 1 | Converter result valid; accepted while convReq is 1 |
| convCode | input | 9 | Converter result code |
| alarmIrq | output | 1 | High-temperature interrupt |
| shutGpio | output | 1 | Shutdown toward the GPIO path |
| shutClk | output | 1 | Shutdown toward the clock/reset unit |

## Verification
The comparisons are driven with per-channel codes set equal to the level, set just above it, and set below it. This shows the >= boundary, and it shows that a channel with its enable cleared stays quiet. One channel is driven with an over/under/over pattern and then a fourth over sample. This separates a counter that restarts on a dip from one that only accumulates. The gap between scans is measured both with no alarm pending and with an alarm pending, which exposes a period choice that is wrong or stuck. Shutdown is tested at both polarities, on each of the two routes, after the code falls back, and after the pending bit is cleared. Together these cover routing, inversion and the sticky hold.

// File: rtl/therm_pkg.sv
package therm_pkg;
  localparam int NUM_CH  = 7;
  localparam int CODE_W  = 9;
  localparam int CHAN_W  = $clog2(NUM_CH);
  localparam int PER_W   = 16;
  localparam int DEB_W   = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int MASK_SH = 16;
  localparam int IDX_W   = 4;

  localparam int BIT_RUN = 0;
  localparam int BIT_POL = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SRC      = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_IRQEN    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RGPIO    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_RCLK     = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_IRQPEND  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_SHUTPEND = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_PER      = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_PERHOT   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_DEBA     = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_DEBS     = 8'h28;

  // upper address bits select a per-channel bank
  localparam logic [1:0] BANK_CTL  = 2'b00;
  localparam logic [1:0] BANK_DATA = 2'b01;
  localparam logic [1:0] BANK_ALVL = 2'b10;
  localparam logic [1:0] BANK_SLVL = 2'b11;

  localparam logic [PER_W-1:0]  PERIOD_RST = PER_W'(5000);
  localparam logic [DEB_W-1:0]  DEB_RST    = DEB_W'(4);
  localparam logic [CODE_W-1:0] LEVEL_RST  = {CODE_W{1'b1}};

  typedef struct packed {
    logic              sampleStb;
    logic [CHAN_W-1:0] chan;
  } scanStb_t;
endpackage

// File: rtl/therm_ctrl.sv
module therm_ctrl
  import therm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              hotMode,
  input  logic [PER_W-1:0]  periodNorm,
  input  logic [PER_W-1:0]  periodHot,
  input  logic              convValid,
  output logic              convReq,
  output logic [CHAN_W-1:0] convChan,
  output scanStb_t          stb
);
  typedef enum logic [0:0] {ST_WAIT, ST_CONV} state_t;

  state_t            state;
  logic [PER_W-1:0]  waitCnt;
  logic [CHAN_W-1:0] chanQ;
  logic [PER_W-1:0]  periodSel;
  logic [PER_W:0]    waitNext;
  logic              waitDone;
  logic              lastChan;
  logic              accept;

  assign periodSel = hotMode ? periodHot : periodNorm;
  assign waitNext  = {1'b0, waitCnt} + {{PER_W{1'b0}}, 1'b1};
  assign waitDone  = waitNext >= {1'b0, periodSel};
  assign lastChan  = chanQ == CHAN_W'(NUM_CH - 1);
  assign convReq   = runEn && (state == ST_CONV);
  assign convChan  = chanQ;
  assign accept    = convReq && convValid;

  assign stb.sampleStb = accept;
  assign stb.chan      = chanQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAIT;
      waitCnt <= '0;
      chanQ   <= '0;
    end else if (!runEn) begin
      state   <= ST_WAIT;
      waitCnt <= '0;
      chanQ   <= '0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (waitDone) begin
            state   <= ST_CONV;
            waitCnt <= '0;
            chanQ   <= '0;
          end else begin
            waitCnt <= waitNext[PER_W-1:0];
          end
        end
        ST_CONV: begin
          if (accept) begin
            if (lastChan) begin
              state <= ST_WAIT;
              chanQ <= '0;
            end else begin
              chanQ <= chanQ + CHAN_W'(1);
            end
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/therm_dp.sv
module therm_dp
  import therm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  scanStb_t          stb,
  input  logic [CODE_W-1:0] convCode,
  output logic              runEn,
  output logic              hotMode,
  output logic [PER_W-1:0]  periodNorm,
  output logic [PER_W-1:0]  periodHot,
  output logic              alarmIrq,
  output logic              shutGpio,
  output logic              shutClk
);
  logic              ctrlPol;
  logic [NUM_CH-1:0] srcEn, irqEn, routeGpio, routeClk;
  logic [NUM_CH-1:0] irqPend, shutPend;
  logic [NUM_CH-1:0] aFire, sFire;
  logic [DEB_W-1:0]  debAlarm, debShut;

  logic [NUM_CH*CODE_W-1:0] dataFlat, aLvlFlat, sLvlFlat;

  logic              wrEn;
  logic [1:0]        bank;
  logic [IDX_W-1:0]  chIdx;
  logic              chIdxOk;
  logic [NUM_CH-1:0] wrVal, wrMask;

  logic unusedWdata;
  assign unusedWdata = ^{busWdata[DATA_W-1:BIT_POL+MASK_SH+1],
                         busWdata[BIT_POL+MASK_SH-1:MASK_SH+NUM_CH]};

  assign wrEn    = busSel && busWr;
  assign bank    = busAddr[ADDR_W-1:ADDR_W-2];
  assign chIdx   = busAddr[IDX_W+1:2];
  assign chIdxOk = chIdx < IDX_W'(NUM_CH);
  assign wrVal   = busWdata[NUM_CH-1:0];
  assign wrMask  = busWdata[MASK_SH+NUM_CH-1:MASK_SH];

  function automatic logic [NUM_CH-1:0] maskedUpd(input logic [NUM_CH-1:0] oldV,
                                                  input logic [NUM_CH-1:0] newV,
                                                  input logic [NUM_CH-1:0] msk);
    return (oldV & ~msk) | (newV & msk);
  endfunction

  // control and configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn      <= 1'b0;
      ctrlPol    <= 1'b0;
      srcEn      <= '0;
      irqEn      <= '0;
      routeGpio  <= '0;
      routeClk   <= '0;
      periodNorm <= PERIOD_RST;
      periodHot  <= PERIOD_RST;
      debAlarm   <= DEB_RST;
      debShut    <= DEB_RST;
    end else if (wrEn) begin
      case (busAddr)
        OFS_CTRL: begin
          if (busWdata[BIT_RUN+MASK_SH]) runEn   <= busWdata[BIT_RUN];
          if (busWdata[BIT_POL+MASK_SH]) ctrlPol <= busWdata[BIT_POL];
        end
        OFS_SRC:    srcEn      <= maskedUpd(srcEn, wrVal, wrMask);
        OFS_IRQEN:  irqEn      <= maskedUpd(irqEn, wrVal, wrMask);
        OFS_RGPIO:  routeGpio  <= maskedUpd(routeGpio, wrVal, wrMask);
        OFS_RCLK:   routeClk   <= maskedUpd(routeClk, wrVal, wrMask);
        OFS_PER:    periodNorm <= busWdata[PER_W-1:0];
        OFS_PERHOT: periodHot  <= busWdata[PER_W-1:0];
        OFS_DEBA:   debAlarm   <= busWdata[DEB_W-1:0];
        OFS_DEBS:   debShut    <= busWdata[DEB_W-1:0];
        default: ;
      endcase
    end
  end

  // per-channel data, levels and debounce counters
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic              hit, overA, overS;
    logic              wrALvl, wrSLvl;
    logic [CODE_W-1:0] dataQ, aLvlQ, sLvlQ;
    logic [DEB_W-1:0]  aCntQ, sCntQ, aCntD, sCntD;

    assign hit    = stb.sampleStb && (stb.chan == CHAN_W'(n));
    assign overA  = convCode >= aLvlQ;
    assign overS  = convCode >= sLvlQ;
    assign wrALvl = wrEn && (bank == BANK_ALVL) && (chIdx == IDX_W'(n));
    assign wrSLvl = wrEn && (bank == BANK_SLVL) && (chIdx == IDX_W'(n));

    assign aCntD = !overA ? '0 : (aCntQ >= debAlarm) ? aCntQ : aCntQ + DEB_W'(1);
    assign sCntD = !overS ? '0 : (sCntQ >= debShut)  ? sCntQ : sCntQ + DEB_W'(1);

    assign aFire[n] = hit && overA && (aCntD >= debAlarm);
    assign sFire[n] = hit && overS && (sCntD >= debShut);

    assign dataFlat[n*CODE_W +: CODE_W] = dataQ;
    assign aLvlFlat[n*CODE_W +: CODE_W] = aLvlQ;
    assign sLvlFlat[n*CODE_W +: CODE_W] = sLvlQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ <= '0;
        aLvlQ <= LEVEL_RST;
        sLvlQ <= LEVEL_RST;
        aCntQ <= '0;
        sCntQ <= '0;
      end else begin
        if (hit) begin
          dataQ <= convCode;
          aCntQ <= aCntD;
          sCntQ <= sCntD;
        end
        if (wrALvl) aLvlQ <= busWdata[CODE_W-1:0];
        if (wrSLvl) sLvlQ <= busWdata[CODE_W-1:0];
      end
    end
  end

  // pending registers: a new event wins over a clear in the same cycle
  logic [NUM_CH-1:0] irqClr, shutClr;
  assign irqClr  = (wrEn && busAddr == OFS_IRQPEND)  ? wrVal : '0;
  assign shutClr = (wrEn && busAddr == OFS_SHUTPEND) ? wrVal : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPend  <= '0;
      shutPend <= '0;
    end else begin
      irqPend  <= (irqPend  & ~irqClr)  | (aFire & irqEn);
      shutPend <= (shutPend & ~shutClr) | (sFire & srcEn);
    end
  end

  logic gpioAct, clkAct;
  assign gpioAct  = |(shutPend & routeGpio);
  assign clkAct   = |(shutPend & routeClk);
  assign shutGpio = ctrlPol ? gpioAct : ~gpioAct;
  assign shutClk  = ctrlPol ? clkAct  : ~clkAct;
  assign alarmIrq = |irqPend;
  assign hotMode  = |irqPend;

  // read path
  always_comb begin
    busRdata = '0;
    if (bank == BANK_CTL) begin
      case (busAddr)
        OFS_CTRL: begin
          busRdata[BIT_RUN] = runEn;
          busRdata[BIT_POL] = ctrlPol;
        end
        OFS_SRC:      busRdata[NUM_CH-1:0] = srcEn;
        OFS_IRQEN:    busRdata[NUM_CH-1:0] = irqEn;
        OFS_RGPIO:    busRdata[NUM_CH-1:0] = routeGpio;
        OFS_RCLK:     busRdata[NUM_CH-1:0] = routeClk;
        OFS_IRQPEND:  busRdata[NUM_CH-1:0] = irqPend;
        OFS_SHUTPEND: busRdata[NUM_CH-1:0] = shutPend;
        OFS_PER:      busRdata[PER_W-1:0]  = periodNorm;
        OFS_PERHOT:   busRdata[PER_W-1:0]  = periodHot;
        OFS_DEBA:     busRdata[DEB_W-1:0]  = debAlarm;
        OFS_DEBS:     busRdata[DEB_W-1:0]  = debShut;
        default: ;
      endcase
    end else if (chIdxOk) begin
      case (bank)
        BANK_DATA: busRdata[CODE_W-1:0] = dataFlat[chIdx*CODE_W +: CODE_W];
        BANK_ALVL: busRdata[CODE_W-1:0] = aLvlFlat[chIdx*CODE_W +: CODE_W];
        BANK_SLVL: busRdata[CODE_W-1:0] = sLvlFlat[chIdx*CODE_W +: CODE_W];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/therm_guard.sv
module therm_guard
  import therm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              convReq,
  output logic [CHAN_W-1:0] convChan,
  input  logic              convValid,
  input  logic [CODE_W-1:0] convCode,
  output logic              alarmIrq,
  output logic              shutGpio,
  output logic              shutClk
);
  scanStb_t         stb;
  logic             runEn, hotMode;
  logic [PER_W-1:0] periodNorm, periodHot;

  therm_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .runEn      (runEn),
    .hotMode    (hotMode),
    .periodNorm (periodNorm),
    .periodHot  (periodHot),
    .convValid  (convValid),
    .convReq    (convReq),
    .convChan   (convChan),
    .stb        (stb)
  );

  therm_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .stb        (stb),
    .convCode   (convCode),
    .runEn      (runEn),
    .hotMode    (hotMode),
    .periodNorm (periodNorm),
    .periodHot  (periodHot),
    .alarmIrq   (alarmIrq),
    .shutGpio   (shutGpio),
    .shutClk    (shutClk)
  );
endmodule

// File: rtl/therm_guard_chk.sv
module therm_guard_chk
  import therm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              convReq,
  input logic [CHAN_W-1:0] convChan,
  input logic              convValid,
  input logic              alarmIrq,
  input logic              shutGpio,
  input logic              shutClk
);
  // R3: requested channel is always a real one
  a_r3_chan_in_range: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> (convChan < CHAN_W'(NUM_CH)));

  // R9: interrupt can only drop through a write to the alarm pending register
  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rstN)
    (alarmIrq && !(busSel && busWr && busAddr == OFS_IRQPEND)) |=> alarmIrq);

  // R7: interrupt rises only on the edge that accepted a sample
  a_r7_irq_rise_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmIrq) |-> $past(convReq && convValid));

  // R13: with no bus write and no sample, shutdown outputs hold
  a_r13_shut_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!(busSel && busWr) && !(convReq && convValid)) |=> ($stable(shutGpio) && $stable(shutClk)));
endmodule

bind therm_guard therm_guard_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .convReq   (convReq),
  .convChan  (convChan),
  .convValid (convValid),
  .alarmIrq  (alarmIrq),
  .shutGpio  (shutGpio),
  .shutClk   (shutClk)
);

// File: tb/therm_guard_tb.sv
module therm_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 7;
  localparam int LAT        = 2;
  localparam int PER_N      = 40;
  localparam int PER_H      = 30;
  localparam int WDOG       = 100000;

  localparam logic [7:0] A_CTRL = 8'h00, A_SRC = 8'h04, A_IRQEN = 8'h08,
                         A_RGPIO = 8'h0C, A_RCLK = 8'h10, A_IPEND = 8'h14,
                         A_SPEND = 8'h18, A_PER = 8'h1C, A_PERH = 8'h20,
                         A_DEBA = 8'h24, A_DEBS = 8'h28;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        convReq;
  logic [2:0]  convChan;
  logic        convValid = 1'b0;
  logic [8:0]  convCode = '0;
  logic        alarmIrq, shutGpio, shutClk;

  therm_guard dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .convReq(convReq), .convChan(convChan),
    .convValid(convValid), .convCode(convCode), .alarmIrq(alarmIrq),
    .shutGpio(shutGpio), .shutClk(shutClk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFail = 0;
  int cyc = 0;
  int scanDone = 0;
  int lastEndCyc = -1;
  int lastGap = -1;
  bit finished = 0;
  logic [8:0] chCode [NCH];
  int expQ [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    chk(tag, v, exp);
  endtask

  task automatic waitScans(input int n);
    int target;
    target = scanDone + n;
    wait (scanDone >= target);
    @(negedge clk);
    @(negedge clk);
  endtask

  // driver: pushes the expected channel order into the scoreboard
  task automatic pushScanOrder();
    for (int c = 0; c < NCH; c++) expQ.push_back(c);
  endtask

  initial begin
    forever begin
      wait (expQ.size() < NCH);
      pushScanOrder();
    end
  end

  // sensor model
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (convValid) begin
        convValid = 1'b0;
        lat = 0;
      end else if (convReq) begin
        if (lat >= LAT - 1) begin
          convValid = 1'b1;
          convCode  = chCode[convChan];
        end else begin
          lat++;
        end
      end
    end
  end

  // monitor: scan order (R3) and inter-scan gap (R5, R6)
  initial begin
    logic prevReq;
    prevReq = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (convReq && !prevReq && lastEndCyc >= 0) lastGap = cyc - lastEndCyc;
      prevReq = convReq;
      if (convReq && convValid) begin
        int e;
        e = (expQ.size() > 0) ? expQ.pop_front() : -1;
        chk("R3 scan order", {29'd0, convChan}, e);
        if (convChan == 3'd6) begin
          lastEndCyc = cyc;
          scanDone++;
        end
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", WDOG, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) chCode[c] = 9'h050;
    chCode[4] = 9'h1AB;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1 control", A_CTRL, 32'h0);
    rdChk("R1 period", A_PER, 32'd5000);
    rdChk("R1 hot period", A_PERH, 32'd5000);
    rdChk("R1 alarm debounce", A_DEBA, 32'd4);
    rdChk("R1 shut debounce", A_DEBS, 32'd4);
    rdChk("R1 alarm pending", A_IPEND, 32'h0);
    rdChk("R1 shut pending", A_SPEND, 32'h0);
    chk("R1 alarmIrq", {31'd0, alarmIrq}, 32'd0);
    chk("R1 shutGpio", {31'd0, shutGpio}, 32'd1);
    chk("R1 shutClk", {31'd0, shutClk}, 32'd1);
    chk("R1 convReq", {31'd0, convReq}, 32'd0);

    busWrite(A_PER, PER_N);
    busWrite(A_PERH, PER_H);
    busWrite(A_DEBA, 2);
    busWrite(A_DEBS, 3);
    busWrite(8'h80 + 8'd8, 32'h100);   // alarm level ch2
    busWrite(8'h80 + 8'd12, 32'h080);  // alarm level ch3
    busWrite(8'hC0 + 8'd16, 32'h100);  // shut level ch4
    busWrite(8'hC0 + 8'd20, 32'h150);  // shut level ch5
    busWrite(8'hC0 + 8'd24, 32'h150);  // shut level ch6

    // R2 masked writes
    busWrite(A_CTRL, 32'h0000_0001);
    rdChk("R2 unmasked run ignored", A_CTRL, 32'h0);
    busWrite(A_IRQEN, 32'h0004_0004);
    busWrite(A_IRQEN, 32'h0008_0004);
    rdChk("R2 irq enable mask", A_IRQEN, 32'h4);
    busWrite(A_CTRL, 32'h0001_0001);
    busWrite(A_CTRL, 32'h0100_0000);
    rdChk("R2 run kept, pol written 0", A_CTRL, 32'h1);

    // R5 normal period, R4 data
    waitScans(2);
    chk("R5 normal gap", lastGap, PER_N + 1);  // accept edge + PERIOD edges
    rdChk("R4 data ch4", 8'h40 + 8'd16, 32'h1AB);
    rdChk("R4 data ch0", 8'h40, 32'h050);

    // R7 alarm at equality, debounce 2; ch3 over but not enabled
    chCode[2] = 9'h100;
    chCode[3] = 9'h0A0;
    waitScans(1);
    rdChk("R7 one sample not enough", A_IPEND, 32'h0);
    waitScans(1);
    rdChk("R7 pending after debounce", A_IPEND, 32'h4);
    chk("R7 alarmIrq", {31'd0, alarmIrq}, 32'd1);
    waitScans(1);
    chk("R6 hot gap", lastGap, PER_H + 1);
    rdChk("R7 disabled ch3 stays clear", A_IPEND, 32'h4);

    // R9 clear by write-back
    chCode[2] = 9'h050;
    waitScans(1);
    busRead(A_IPEND, v);
    busWrite(A_IPEND, v);
    rdChk("R9 cleared", A_IPEND, 32'h0);
    chk("R9 alarmIrq low", {31'd0, alarmIrq}, 32'd0);
    waitScans(2);
    chk("R6 back to normal gap", lastGap, PER_N + 1);

    // R8 dip restarts debounce
    chCode[2] = 9'h1F0;
    waitScans(1);
    chCode[2] = 9'h0FF;
    waitScans(1);
    chCode[2] = 9'h1F0;
    waitScans(1);
    rdChk("R8 broken run sets nothing", A_IPEND, 32'h0);
    waitScans(1);
    rdChk("R8 second consecutive sets", A_IPEND, 32'h4);
    chCode[2] = 9'h050;
    waitScans(1);
    busWrite(A_IPEND, 32'h7F);

    // R10/R11 shutdown on ch5 via GPIO route; ch4 over but source disabled
    busWrite(A_SRC, 32'h0020_0020);
    busWrite(A_RGPIO, 32'h0030_0030);
    chCode[5] = 9'h160;
    waitScans(2);
    chk("R10 below debounce no shutdown", {31'd0, shutGpio}, 32'd1);
    waitScans(1);
    chk("R11 gpio active low", {31'd0, shutGpio}, 32'd0);
    chk("R11 clk route idle", {31'd0, shutClk}, 32'd1);
    rdChk("R10 shut pending ch5 only", A_SPEND, 32'h20);

    // R12 polarity
    busWrite(A_CTRL, 32'h0100_0100);
    rdChk("R12 control", A_CTRL, 32'h101);
    chk("R12 gpio active high", {31'd0, shutGpio}, 32'd1);
    chk("R12 clk inactive low", {31'd0, shutClk}, 32'd0);

    // R13 sticky
    chCode[5] = 9'h050;
    waitScans(2);
    chk("R13 gpio held", {31'd0, shutGpio}, 32'd1);
    busRead(A_SPEND, v);
    busWrite(A_SPEND, v);
    chk("R13 released after clear", {31'd0, shutGpio}, 32'd0);

    // R11 clock/reset route on ch6
    busWrite(A_SRC, 32'h0040_0040);
    busWrite(A_RCLK, 32'h0040_0040);
    chCode[6] = 9'h1FF;
    waitScans(3);
    chk("R11 clk route active", {31'd0, shutClk}, 32'd1);
    chk("R11 gpio route idle", {31'd0, shutGpio}, 32'd0);
    rdChk("R10 shut pending ch6", A_SPEND, 32'h40);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule